// File: doc/BRIEF.md
# Script Processor Flow-Control Unit

This unit executes the conditional Return and Interrupt steps of a small script-driven controller. It keeps three 32-bit registers: the instruction pointer that the fetch logic reads, a return-address register that the call logic loads from outside, and a status-vector register that takes the address field of every executed instruction. For each decoded instruction it tests a condition and then either advances the pointer, reloads it from the return-address register, or raises an active-low interrupt and stops.

The condition is either the ALU carry flag or a comparison of the current bus phase and/or the current data byte against values carried in the instruction. A sense bit selects whether the step is taken when the test matches or when it fails. After a taken interrupt the unit stays halted until the host writes a new pointer. The interrupt line stays low until the host acknowledges it, and the status vector tells the service routine which interrupt step fired.

Top module: `scr_flow_ctl`

## Requirements
- R1: In reset, ip_addr, status_vec and the return-address register are zero, irq_n is 1, run_status is 2'b00 and fetch_en is 1.
- R2: When cond_carry is 1 the raw test result is alu_carry, and the phase and data compare fields have no effect.
- R3: When cond_carry is 0 the raw result is a match only if every enabled compare matches. The phase compare needs bus_phase equal to exp_phase. The data compare needs bus_data equal to exp_data on every bit whose exp_mask bit is 0, and a mask bit of 1 excludes that bit. With neither compare enabled the raw result is a match.
- R4: With cond_sense at 1 the step is taken on a raw match, and with cond_sense at 0 it is taken on a raw mismatch.
- R5: An instruction executes when instr_valid is 1, the unit is not halted and host_ptr_wr is 0. An executed instruction that is not a taken Return sets ip_addr to ip_addr + 8 on the next cycle. This covers a Return whose condition fails. instr_op encodes 2'b01 as Return, 2'b10 as Interrupt, and 2'b00 or 2'b11 as a plain sequential step.
- R6: A taken Return loads ip_addr from the return-address register as it stood before that edge. The unit does not check for a prior call and raises no error.
- R7: Every executed instruction copies addr_field into status_vec. In all other cycles status_vec holds its value.
- R8: A taken Interrupt drives irq_n low from the next cycle and halts the unit. irq_n then stays low until a cycle with host_irq_ack at 1. If a taken Interrupt and an acknowledge fall in the same cycle, irq_n stays low.
- R9: While halted, fetch_en is 0 and instructions have no effect on ip_addr or status_vec. A host_ptr_wr clears the halt, so fetch_en is 1 in the next cycle.
- R10: host_ptr_wr loads host_ptr_data into ip_addr. If an instruction is presented in the same cycle, that instruction is discarded.
- R11: run_status is 2'b10 while irq_n is low. Otherwise it is 2'b01 while halted and 2'b00 while running.
- R12: ret_load writes ret_load_addr into the return-address register. A Return taken in the same cycle uses the older value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Decoded instruction presented this cycle |
| instr_op | input | 2 | 01 Return, 10 Interrupt, other values sequential |
| cond_carry | input | 1 | Use the carry flag as the test |
| cond_phase_en | input | 1 | Enable the phase compare |
| cond_data_en | input | 1 | Enable the data compare |
| cond_sense | input | 1 | 1 takes the step on match, 0 on mismatch |
| exp_phase | input | 3 | Expected phase code |
| exp_data | input | 8 | Expected data byte |
| exp_mask | input | 8 | Data bits to exclude from the compare (1 = excluded) |
| addr_field | input | 32 | Instruction address field, used as the status vector |
| bus_phase | input | 3 | Current bus phase |
| bus_data | input | 8 | Current data byte |
| alu_carry | input | 1 | ALU carry flag |
| ret_load | input | 1 | Load the return-address register |
| ret_load_addr | input | 32 | Value for the return-address register |
| host_ptr_wr | input | 1 | Host write of the instruction pointer |
| host_ptr_data | input | 32 | Host pointer value |
| host_irq_ack | input | 1 | Host acknowledge that clears the interrupt |
| irq_n | output | 1 | Active-low interrupt request |
| ip_addr | output | 32 | Instruction pointer |
| status_vec | output | 32 | Address field of the last executed instruction |
| run_status | output | 2 | 00 running, 01 halted, 10 interrupt pending |
| fetch_en | output | 1 | High while the unit runs |

## Verification
Two same-cycle collisions matter here. The first is a host pointer write arriving while an instruction is presented and the unit is running: the write must win and the instruction must leave no trace in status_vec. The second is a return-address load arriving in the same cycle as a taken Return, which must use the older address. Random stimulus raises host writes, return-address loads, valid instructions and acknowledges independently every cycle, so both collisions recur many times. A behavioural reference model in the bench predicts the pointer, vector, interrupt line and status for each cycle and compares them against the design on every clock.

// File: rtl/scr_flow_pkg.sv
package scr_flow_pkg;

  typedef enum logic [1:0] {
    OP_SEQ = 2'b00,
    OP_RET = 2'b01,
    OP_INT = 2'b10,
    OP_RSV = 2'b11
  } flow_op_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'b00,
    ST_HALT = 2'b01,
    ST_IRQ  = 2'b10
  } run_state_e;

endpackage

// File: rtl/scr_cond_eval.sv
module scr_cond_eval #(
  parameter int PHASE_W = 3,
  parameter int DATA_W  = 8
) (
  input  logic               use_carry_i,
  input  logic               phase_en_i,
  input  logic               data_en_i,
  input  logic               sense_i,
  input  logic [PHASE_W-1:0] exp_phase_i,
  input  logic [DATA_W-1:0]  exp_data_i,
  input  logic [DATA_W-1:0]  exp_mask_i,
  input  logic [PHASE_W-1:0] bus_phase_i,
  input  logic [DATA_W-1:0]  bus_data_i,
  input  logic               carry_i,
  output logic               raw_match_o,
  output logic               cond_hit_o
);

  // Bits excluded by the mask never cause a miss.
  function automatic logic masked_equal(input logic [DATA_W-1:0] a,
                                        input logic [DATA_W-1:0] b,
                                        input logic [DATA_W-1:0] excl);
    return ((a ^ b) & ~excl) == '0;
  endfunction

  logic phase_ok;
  logic data_ok;
  logic cmp_match;

  always_comb begin
    phase_ok    = !phase_en_i || (bus_phase_i == exp_phase_i);
    data_ok     = !data_en_i  || masked_equal(bus_data_i, exp_data_i, exp_mask_i);
    cmp_match   = phase_ok && data_ok;
    raw_match_o = use_carry_i ? carry_i : cmp_match;
    cond_hit_o  = sense_i ? raw_match_o : !raw_match_o;
  end

endmodule

// File: rtl/scr_ptr_regs.sv
module scr_ptr_regs #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_i,
  input  logic              ret_take_i,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] host_data_i,
  input  logic              ret_wr_i,
  input  logic [ADDR_W-1:0] ret_data_i,
  input  logic [ADDR_W-1:0] addr_field_i,
  output logic [ADDR_W-1:0] ip_q,
  output logic [ADDR_W-1:0] ret_q,
  output logic [ADDR_W-1:0] save_q
);

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] cur);
    return cur + STEP_V;
  endfunction

  logic [ADDR_W-1:0] ip_d;

  always_comb begin
    if (host_wr_i)       ip_d = host_data_i;
    else if (ret_take_i) ip_d = ret_q;
    else if (exec_i)     ip_d = seq_next(ip_q);
    else                 ip_d = ip_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q   <= '0;
      ret_q  <= '0;
      save_q <= '0;
    end else begin
      ip_q <= ip_d;
      if (ret_wr_i) ret_q  <= ret_data_i;
      if (exec_i)   save_q <= addr_field_i;
    end
  end

  // R5
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && !ret_take_i && !host_wr_i) |=> (ip_q == $past(ip_q) + STEP_V));

  // R6
  ret_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_take_i && !host_wr_i) |=> (ip_q == $past(ret_q)));

  // R10
  host_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_i |=> (ip_q == $past(host_data_i)));

  // R7
  save_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> $stable(save_q));

endmodule

// File: rtl/scr_run_ctl.sv
module scr_run_ctl
  import scr_flow_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       int_take_i,
  input  logic       host_wr_i,
  input  logic       irq_ack_i,
  output logic       halted_q,
  output logic       irq_n_o,
  output run_state_e state_o
);

  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (host_wr_i)       halted_q <= 1'b0;
      else if (int_take_i) halted_q <= 1'b1;
      if (int_take_i)      pend_q <= 1'b1;
      else if (irq_ack_i)  pend_q <= 1'b0;
    end
  end

  always_comb begin
    irq_n_o = !pend_q;
    if (pend_q)        state_o = ST_IRQ;
    else if (halted_q) state_o = ST_HALT;
    else               state_o = ST_RUN;
  end

  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_take_i |=> !irq_n_o);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n_o && !irq_ack_i) |=> !irq_n_o);

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !host_wr_i) |=> halted_q);

  // R9
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_i |=> !halted_q);

endmodule

// File: rtl/scr_flow_ctl.sv
module scr_flow_ctl
  import scr_flow_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PHASE_W = 3,
  parameter int DATA_W  = 8,
  parameter int STEP    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [1:0]         instr_op,
  input  logic               cond_carry,
  input  logic               cond_phase_en,
  input  logic               cond_data_en,
  input  logic               cond_sense,
  input  logic [PHASE_W-1:0] exp_phase,
  input  logic [DATA_W-1:0]  exp_data,
  input  logic [DATA_W-1:0]  exp_mask,
  input  logic [ADDR_W-1:0]  addr_field,
  input  logic [PHASE_W-1:0] bus_phase,
  input  logic [DATA_W-1:0]  bus_data,
  input  logic               alu_carry,
  input  logic               ret_load,
  input  logic [ADDR_W-1:0]  ret_load_addr,
  input  logic               host_ptr_wr,
  input  logic [ADDR_W-1:0]  host_ptr_data,
  input  logic               host_irq_ack,
  output logic               irq_n,
  output logic [ADDR_W-1:0]  ip_addr,
  output logic [ADDR_W-1:0]  status_vec,
  output logic [1:0]         run_status,
  output logic               fetch_en
);

  // Named internal events, visible to the assertions.
  logic       cond_hit;
  logic       raw_match;
  logic       halted;
  logic       exec_ev;
  logic       ret_take_ev;
  logic       int_take_ev;
  logic [ADDR_W-1:0] ret_addr;
  run_state_e state;
  flow_op_e   op;

  assign op          = flow_op_e'(instr_op);
  assign exec_ev     = instr_valid && !halted && !host_ptr_wr;
  assign ret_take_ev = exec_ev && (op == OP_RET) && cond_hit;
  assign int_take_ev = exec_ev && (op == OP_INT) && cond_hit;

  scr_cond_eval #(.PHASE_W(PHASE_W), .DATA_W(DATA_W)) u_cond (
    .use_carry_i (cond_carry),
    .phase_en_i  (cond_phase_en),
    .data_en_i   (cond_data_en),
    .sense_i     (cond_sense),
    .exp_phase_i (exp_phase),
    .exp_data_i  (exp_data),
    .exp_mask_i  (exp_mask),
    .bus_phase_i (bus_phase),
    .bus_data_i  (bus_data),
    .carry_i     (alu_carry),
    .raw_match_o (raw_match),
    .cond_hit_o  (cond_hit)
  );

  scr_ptr_regs #(.ADDR_W(ADDR_W), .STEP(STEP)) u_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .exec_i       (exec_ev),
    .ret_take_i   (ret_take_ev),
    .host_wr_i    (host_ptr_wr),
    .host_data_i  (host_ptr_data),
    .ret_wr_i     (ret_load),
    .ret_data_i   (ret_load_addr),
    .addr_field_i (addr_field),
    .ip_q         (ip_addr),
    .ret_q        (ret_addr),
    .save_q       (status_vec)
  );

  scr_run_ctl u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_take_i (int_take_ev),
    .host_wr_i  (host_ptr_wr),
    .irq_ack_i  (host_irq_ack),
    .halted_q   (halted),
    .irq_n_o    (irq_n),
    .state_o    (state)
  );

  assign run_status = state;
  assign fetch_en   = !halted;

  // R2
  carry_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_carry |-> (raw_match == alu_carry));

  // R10
  host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ptr_wr && instr_valid) |=> $stable(status_vec));

  // R12
  ret_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_take_ev && ret_load && !host_ptr_wr) |=> (ip_addr == $past(ret_addr)));

endmodule

// File: tb/sim_scr_flow_ctl.sv
`timescale 1ns/1ps
module sim_scr_flow_ctl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [1:0]  instr_op;
  logic        cond_carry, cond_phase_en, cond_data_en, cond_sense;
  logic [2:0]  exp_phase;
  logic [7:0]  exp_data, exp_mask;
  logic [31:0] addr_field;
  logic [2:0]  bus_phase;
  logic [7:0]  bus_data;
  logic        alu_carry;
  logic        ret_load;
  logic [31:0] ret_load_addr;
  logic        host_ptr_wr;
  logic [31:0] host_ptr_data;
  logic        host_irq_ack;
  logic        irq_n;
  logic [31:0] ip_addr, status_vec;
  logic [1:0]  run_status;
  logic        fetch_en;

  always #2.5 clk = ~clk;

  scr_flow_ctl u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
    .cond_carry(cond_carry), .cond_phase_en(cond_phase_en),
    .cond_data_en(cond_data_en), .cond_sense(cond_sense),
    .exp_phase(exp_phase), .exp_data(exp_data), .exp_mask(exp_mask),
    .addr_field(addr_field), .bus_phase(bus_phase), .bus_data(bus_data),
    .alu_carry(alu_carry), .ret_load(ret_load), .ret_load_addr(ret_load_addr),
    .host_ptr_wr(host_ptr_wr), .host_ptr_data(host_ptr_data),
    .host_irq_ack(host_irq_ack), .irq_n(irq_n), .ip_addr(ip_addr),
    .status_vec(status_vec), .run_status(run_status), .fetch_en(fetch_en)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Reference model state
  logic [31:0] m_ip, m_ret, m_save;
  bit          m_halt, m_pend;
  string       ip_tag, save_tag, irq_tag;

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // R2 R3 R4: condition restated bit by bit
  function automatic bit ref_cond();
    bit raw;
    if (cond_carry) raw = alu_carry;
    else begin
      raw = 1;
      if (cond_phase_en && bus_phase != exp_phase) raw = 0;
      if (cond_data_en)
        for (int i = 0; i < 8; i++)
          if (!exp_mask[i] && bus_data[i] != exp_data[i]) raw = 0;
    end
    return cond_sense ? raw : !raw;
  endfunction

  task automatic compare_all();
    bit [1:0] st;
    st = m_pend ? 2'b10 : (m_halt ? 2'b01 : 2'b00);
    cmp(ip_tag, ip_addr, m_ip);
    cmp(save_tag, status_vec, m_save);
    cmp(irq_tag, {31'd0, irq_n}, {31'd0, !m_pend});
    cmp("R11 run_status", {30'd0, run_status}, {30'd0, st});
    cmp("R9 fetch_en", {31'd0, fetch_en}, {31'd0, !m_halt});
  endtask

  task automatic drive_random();
    instr_valid   = ($urandom_range(0, 9) < 7);
    instr_op      = 2'($urandom_range(0, 3));
    cond_carry    = ($urandom_range(0, 3) == 0);
    cond_phase_en = $urandom_range(0, 1) == 1;
    cond_data_en  = $urandom_range(0, 1) == 1;
    cond_sense    = $urandom_range(0, 1) == 1;
    bus_phase     = 3'($urandom_range(0, 7));
    bus_data      = 8'($urandom_range(0, 255));
    alu_carry     = $urandom_range(0, 1) == 1;
    exp_phase     = ($urandom_range(0, 1) == 1) ? bus_phase : 3'($urandom_range(0, 7));
    exp_data      = ($urandom_range(0, 1) == 1) ? bus_data : (bus_data ^ (8'd1 << $urandom_range(0, 7)));
    exp_mask      = ($urandom_range(0, 2) == 0) ? 8'($urandom_range(0, 255)) : 8'h00;
    addr_field    = $urandom;
    ret_load      = ($urandom_range(0, 9) == 0); // R12
    ret_load_addr = {$urandom} & 32'hFFFF_FFF8;
    host_ptr_wr   = m_halt ? ($urandom_range(0, 4) == 0) : ($urandom_range(0, 29) == 0);
    host_ptr_data = {$urandom} & 32'hFFFF_FFF8;
    host_irq_ack  = ($urandom_range(0, 7) == 0);
  endtask

  // Predict the state the design holds after the coming edge.
  task automatic model_step();
    bit exec, hit, rtake, itake;
    exec  = instr_valid && !m_halt && !host_ptr_wr;
    hit   = ref_cond();
    rtake = exec && instr_op == 2'b01 && hit;
    itake = exec && instr_op == 2'b10 && hit;
    if (host_ptr_wr)   ip_tag = "R10 host write wins";
    else if (m_halt)   ip_tag = "R9 halted ip";
    else if (exec && instr_op == 2'b01)
      ip_tag = cond_carry ? "R6 R2 R12 return" : (cond_sense ? "R6 R3 R12 return" : "R6 R4 return");
    else               ip_tag = "R5 sequential";
    save_tag = host_ptr_wr ? "R10 discarded vector" : (m_halt ? "R9 halted vector" : "R7 vector");
    irq_tag  = (itake && host_irq_ack) ? "R8 set beats ack" : "R8 irq_n";
    if (host_ptr_wr) m_ip = host_ptr_data;
    else if (rtake)  m_ip = m_ret;
    else if (exec)   m_ip = m_ip + 32'd8;
    if (ret_load) m_ret = ret_load_addr;
    if (exec) m_save = addr_field;
    if (host_ptr_wr) m_halt = 0;
    else if (itake)  m_halt = 1;
    if (itake) m_pend = 1;
    else if (host_irq_ack) m_pend = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0;
    m_ip = 0; m_ret = 0; m_save = 0; m_halt = 0; m_pend = 0;
    drive_random();
    instr_valid = 1; host_ptr_wr = 1; host_irq_ack = 0;
    repeat (3) @(negedge clk);
    ip_tag = "R1 reset ip"; save_tag = "R1 reset vector"; irq_tag = "R1 reset irq_n";
    compare_all();
    @(negedge clk);
    rst_n = 1;
    drive_random();
    model_step();
    for (int cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      compare_all();
      drive_random();
      model_step();
    end
    @(negedge clk);
    compare_all();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule